// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits between the byte output of an HDLC receive deframer and the write port of a receive FIFO. Each incoming frame carries a two-byte address field. The block compares that field with two programmable patterns, and each pattern has its own enable. A frame that passes is forwarded to the FIFO byte by byte. A frame that fails is dropped whole, so the FIFO never sees any of its bytes.

The first two bytes of a frame are parked in a small hold buffer until the second byte has been judged. The block then releases both bytes in order and passes the rest of the frame straight through. Frames that are too short or that are aborted are discarded. A new start-of-frame always restarts address capture. The pattern registers may change at any time, but each frame is judged with the values captured at its start-of-frame.

The deframer produces at most one byte per bit-time octet. For that reason the input must never present bytes on two consecutive clock cycles. The block uses this guaranteed idle cycle to release the second held byte.

Top module: `hdlc_addr_filter`

## Requirements
- R1: With the first-byte enable set, the first address byte matches only if its bits 7..2 equal bits 7..2 of the first pattern. Bits 1..0 of the byte and of the pattern have no effect.
- R2: With the second-byte enable set, the second address byte matches only if its bits 7..1 equal bits 7..1 of the second pattern. Bit 0 of the byte and of the pattern has no effect.
- R3: A second byte whose bits 7..1 are all ones is a broadcast. It counts as a match whatever the second pattern holds.
- R4: A byte whose enable is 0 is ignored in the decision. With both enables at 0, every frame of two or more bytes is accepted.
- R5: A frame that fails the comparison produces no FIFO write at all.
- R6: An accepted frame is written in order with every byte. The first write carries the start flag, and the write of the byte that came with the end marker carries the end flag. The first byte is written in the cycle after the second byte is presented, and the second byte one cycle later. Each later byte is written one cycle after it is presented.
- R7: Nothing is written before the second address byte has been judged. Out of reset, no write is pending.
- R8: A frame whose first byte also carries the end marker is discarded.
- R9: An abort pulse ends the current frame and returns the block to idle. An unaccepted frame writes nothing. An accepted frame writes no further bytes, including a held second byte not yet released. An abort takes priority over a byte presented in the same cycle.
- R10: Pattern and enable inputs are captured at the start-of-frame byte. Changes made later in the frame do not affect that frame.
- R11: A start-of-frame byte in any state starts a new frame, and the previous frame is cut off without an end flag. Bytes arriving in idle without a start flag are ignored.
- R12: The input valid strobe is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_abort | input | 1 | Pulse: current frame aborted |
| addr1_pat | input | 8 | First-byte pattern (bits 7..2 used) |
| addr1_en | input | 1 | Enable first-byte comparison |
| addr2_pat | input | 8 | Second-byte pattern (bits 7..1 used) |
| addr2_en | input | 1 | Enable second-byte comparison |
| out_valid | output | 1 | FIFO write strobe |
| out_data | output | 8 | Byte to write |
| out_sof | output | 1 | Write is the first byte of a frame |
| out_eof | output | 1 | Write is the last byte of a frame |

## Verification
The in-RTL assertions check, on every cycle, the properties that hold at all times. A rejected frame's drop state never writes. A start-flagged write appears only while the held second byte is pending, and that release state lasts exactly one cycle. A one-byte frame causes no write. With both enables clear, an accepted decision leads straight to a start-flagged write. They also watch the input-spacing rule. The pattern-dependent matching has to be shown by the bench's scenarios. This covers the bit positions that are ignored, broadcast, and sampling at start-of-frame. The same goes for abort and restart at each point of a frame, and for the exact byte order and flags of a forwarded frame. A sweep covers every upper seven-bit second byte against every enable combination and against first bytes that differ from the pattern in each single bit.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

    localparam int AF_DW     = 8;  // HDLC octet width
    localparam int AF_HOLD_N = 2;  // address bytes held before the decision
    localparam int AF_LSB1   = 2;  // lowest compared bit of first byte
    localparam int AF_LSB2   = 1;  // lowest compared bit of second byte

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR2,
        ST_FLUSH,
        ST_PASS,
        ST_DROP
    } af_state_e;

    typedef struct packed {
        af_state_e          state;
        logic [AF_DW-1:0]   pat1;
        logic [AF_DW-1:0]   pat2;
        logic               en1;
        logic               en2;
        logic               b2_last;
        logic               out_valid;
        logic [AF_DW-1:0]   out_data;
        logic               out_sof;
        logic               out_eof;
    } af_regs_t;

endpackage

// File: rtl/hdlc_af_hold.sv
module hdlc_af_hold #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(DEPTH)-1:0]     wr_idx,
    input  logic [DW-1:0]                wr_data,
    output logic [DEPTH-1:0][DW-1:0]     rd_data
);

    localparam int IW = $clog2(DEPTH);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DW-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IW'(g))) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign rd_data[g] = ent_q;
    end

endmodule

// File: rtl/hdlc_af_match.sv
module hdlc_af_match #(
    parameter int DW   = 8,
    parameter int LSB1 = 2,
    parameter int LSB2 = 1
) (
    input  logic [DW-1:0] byte1,
    input  logic [DW-1:0] byte2,
    input  logic [DW-1:0] pat1,
    input  logic [DW-1:0] pat2,
    input  logic          en1,
    input  logic          en2,
    output logic          hit1,
    output logic          hit2,
    output logic          accept
);

    localparam int W2 = DW - LSB2;

    logic bcast;
    logic unused_low_bits;

    assign unused_low_bits = ^{byte1[LSB1-1:0], pat1[LSB1-1:0],
                               byte2[LSB2-1:0], pat2[LSB2-1:0]};

    always_comb begin
        bcast  = (byte2[DW-1:LSB2] == {W2{1'b1}});
        hit1   = !en1 || (byte1[DW-1:LSB1] == pat1[DW-1:LSB1]);
        hit2   = !en2 || bcast || (byte2[DW-1:LSB2] == pat2[DW-1:LSB2]);
        accept = hit1 && hit2;
    end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hdlc_af_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_abort,
    input  logic [7:0]  addr1_pat,
    input  logic        addr1_en,
    input  logic [7:0]  addr2_pat,
    input  logic        addr2_en,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof
);

    localparam int IW = $clog2(AF_HOLD_N);

    af_regs_t q, d;

    logic                          hold_we;
    logic [IW-1:0]                 hold_idx;
    logic [AF_HOLD_N-1:0][AF_DW-1:0] held;
    logic                          hit1, hit2, accept;
    logic                          unused_hits;

    assign unused_hits = hit1 ^ hit2;

    hdlc_af_hold #(
        .DW    (AF_DW),
        .DEPTH (AF_HOLD_N)
    ) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hold_we),
        .wr_idx  (hold_idx),
        .wr_data (in_data),
        .rd_data (held)
    );

    hdlc_af_match #(
        .DW   (AF_DW),
        .LSB1 (AF_LSB1),
        .LSB2 (AF_LSB2)
    ) match_i (
        .byte1  (held[0]),
        .byte2  (in_data),
        .pat1   (q.pat1),
        .pat2   (q.pat2),
        .en1    (q.en1),
        .en2    (q.en2),
        .hit1   (hit1),
        .hit2   (hit2),
        .accept (accept)
    );

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.out_sof   = 1'b0;
        d.out_eof   = 1'b0;
        hold_we     = 1'b0;
        hold_idx    = '0;

        if (in_abort) begin
            d.state = ST_IDLE;
        end else if (in_valid && in_sof) begin
            hold_we  = 1'b1;
            hold_idx = IW'(0);
            d.pat1   = addr1_pat;
            d.pat2   = addr2_pat;
            d.en1    = addr1_en;
            d.en2    = addr2_en;
            d.state  = in_eof ? ST_IDLE : ST_ADDR2;
        end else begin
            unique case (q.state)
                ST_ADDR2: begin
                    if (in_valid) begin
                        hold_we  = 1'b1;
                        hold_idx = IW'(1);
                        if (accept) begin
                            d.out_valid = 1'b1;
                            d.out_data  = held[0];
                            d.out_sof   = 1'b1;
                            d.b2_last   = in_eof;
                            d.state     = ST_FLUSH;
                        end else begin
                            d.state = in_eof ? ST_IDLE : ST_DROP;
                        end
                    end
                end
                ST_FLUSH: begin
                    d.out_valid = 1'b1;
                    d.out_data  = held[1];
                    d.out_eof   = q.b2_last;
                    d.state     = q.b2_last ? ST_IDLE : ST_PASS;
                end
                ST_PASS: begin
                    if (in_valid) begin
                        d.out_valid = 1'b1;
                        d.out_data  = in_data;
                        d.out_eof   = in_eof;
                        if (in_eof) begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_DROP: begin
                    if (in_valid && in_eof) begin
                        d.state = ST_IDLE;
                    end
                end
                default: begin
                    d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.out_valid;
    assign out_data  = q.out_data;
    assign out_sof   = q.out_sof;
    assign out_eof   = q.out_eof;

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_DROP) |-> !out_valid);  // R5

    AST_SOF_AFTER_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> (q.state == ST_FLUSH));  // R7

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_FLUSH) |=> (q.state != ST_FLUSH));  // R6

    AST_SHORT_FRAME_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && in_eof && !in_abort) |=> !out_valid);  // R8

    AST_OPEN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_ADDR2) && in_valid && !in_sof && !in_abort && !q.en1 && !q.en2)
        |=> (out_valid && out_sof));  // R4

    AST_IN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !in_valid);  // R12

endmodule

// File: tb/hdlc_addr_filter_tb_top.sv
module hdlc_addr_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_abort = 1'b0;
    logic [7:0] addr1_pat = '0;
    logic       addr1_en = 1'b0;
    logic [7:0] addr2_pat = '0;
    logic       addr2_en = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sof;
    logic       out_eof;

    always #5 clk = ~clk;

    hdlc_addr_filter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_abort  (in_abort),
        .addr1_pat (addr1_pat),
        .addr1_en  (addr1_en),
        .addr2_pat (addr2_pat),
        .addr2_en  (addr2_en),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eof   (out_eof)
    );

    int         n_total = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;
    int         cap_n   = 0;
    logic [7:0] cap_d   [16];
    logic       cap_s   [16];
    logic       cap_e   [16];
    logic [7:0] exp_d   [16];

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (cap_n < 16) begin
                cap_d[cap_n] = out_data;
                cap_s[cap_n] = out_sof;
                cap_e[cap_n] = out_eof;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input bit s, input bit e);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        in_abort = 1'b1;
        @(negedge clk);
        in_abort = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // n expected writes from exp_d; sof flags on the first write; end flag on the last if last_eof
    task automatic check_writes(input string req, input int n, input bit last_eof);
        chk(cap_n == n, req, "write count", cap_n, n);
        for (int i = 0; i < n && i < cap_n && i < 16; i++) begin
            chk(cap_d[i] == exp_d[i], req, "write data", cap_d[i], exp_d[i]);
            chk(cap_s[i] == (i == 0), req, "sof flag", cap_s[i], (i == 0));
            chk(cap_e[i] == (last_eof && i == n - 1), req, "eof flag",
                cap_e[i], (last_eof && i == n - 1));
        end
        cap_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [7:0] b1, b2, pay, p1, p2;
        bit         acc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: nothing written out of reset
        chk(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
        cap_n = 0;

        // Sweep: R1 R2 R3 R4 R5 R6
        for (int e = 0; e < 4; e++) begin
            for (int k = 0; k < 9; k++) begin
                for (int u = 0; u < 128; u++) begin
                    p1 = {6'b101101, 2'(k + e)};
                    p2 = {7'h53, u[1]};
                    b1 = p1;
                    b1[1:0] = ~p1[1:0];
                    if (k >= 1 && k <= 6) b1[k + 1] = ~b1[k + 1];
                    if (k == 7) b1[0] = ~b1[0];
                    if (k == 8) b1[1] = ~b1[1];
                    b2  = {u[6:0], ~u[0]};
                    pay = 8'(u) ^ 8'h5A;
                    acc = (!e[0] || (b1[7:2] == p1[7:2])) &&
                          (!e[1] || (b2[7:1] == 7'h7F) || (b2[7:1] == p2[7:1]));
                    addr1_pat = p1; addr2_pat = p2;
                    addr1_en  = e[0]; addr2_en = e[1];
                    cap_n = 0;
                    put(b1, 1'b1, 1'b0);
                    put(b2, 1'b0, 1'b0);
                    put(pay, 1'b0, 1'b1);
                    settle();
                    exp_d[0] = b1; exp_d[1] = b2; exp_d[2] = pay;
                    check_writes("R1/R2/R3/R4/R5/R6 sweep", acc ? 3 : 0, 1'b1);
                end
            end
        end

        // R4: both enables clear accepts anything
        addr1_en = 1'b0; addr2_en = 1'b0; addr1_pat = 8'h00; addr2_pat = 8'h00;
        put(8'hFF, 1'b1, 1'b0); put(8'h12, 1'b0, 1'b0); put(8'h34, 1'b0, 1'b1); settle();
        exp_d[0] = 8'hFF; exp_d[1] = 8'h12; exp_d[2] = 8'h34;
        check_writes("R4", 3, 1'b1);

        // R6: two-byte frame, end flag on second write
        put(8'hA0, 1'b1, 1'b0); put(8'hA1, 1'b0, 1'b1); settle();
        exp_d[0] = 8'hA0; exp_d[1] = 8'hA1;
        check_writes("R6", 2, 1'b1);

        // R8: one-byte frame discarded
        put(8'hC3, 1'b1, 1'b1); settle();
        check_writes("R8", 0, 1'b0);

        // R9: abort before decision
        put(8'h11, 1'b1, 1'b0); pulse_abort(); put(8'h22, 1'b0, 1'b0);
        put(8'h33, 1'b0, 1'b1); settle();
        check_writes("R9 abort before decision", 0, 1'b0);

        // R9: abort while second byte is held
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h40; in_sof = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h41;
        @(negedge clk);
        in_valid = 1'b0; in_abort = 1'b1;
        @(negedge clk);
        in_abort = 1'b0;
        settle();
        exp_d[0] = 8'h40;
        check_writes("R9 abort during release", 1, 1'b0);

        // R9: abort mid payload of accepted frame
        put(8'h50, 1'b1, 1'b0); put(8'h51, 1'b0, 1'b0); put(8'h52, 1'b0, 1'b0);
        pulse_abort(); put(8'h53, 1'b0, 1'b1); settle();
        exp_d[0] = 8'h50; exp_d[1] = 8'h51; exp_d[2] = 8'h52;
        check_writes("R9 abort after accept", 3, 1'b0);

        // R9: abort wins over a byte in the same cycle
        put(8'h60, 1'b1, 1'b0); put(8'h61, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h62; in_abort = 1'b1; in_eof = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_abort = 1'b0; in_eof = 1'b0;
        settle();
        exp_d[0] = 8'h60; exp_d[1] = 8'h61;
        check_writes("R9 abort with byte", 2, 1'b0);

        // R10: patterns sampled at start-of-frame
        addr1_en = 1'b1; addr2_en = 1'b1; addr1_pat = 8'h84; addr2_pat = 8'h42;
        put(8'h84, 1'b1, 1'b0);
        addr1_pat = 8'h00; addr2_pat = 8'h00;
        put(8'h42, 1'b0, 1'b0); put(8'h99, 1'b0, 1'b1); settle();
        exp_d[0] = 8'h84; exp_d[1] = 8'h42; exp_d[2] = 8'h99;
        check_writes("R10 late change ignored", 3, 1'b1);
        put(8'h84, 1'b1, 1'b0); put(8'h42, 1'b0, 1'b0); put(8'h99, 1'b0, 1'b1); settle();
        check_writes("R10 new values used", 0, 1'b0);

        // R11: new start-of-frame cuts off an accepted frame
        addr1_en = 1'b0; addr2_en = 1'b0;
        put(8'h70, 1'b1, 1'b0); put(8'h71, 1'b0, 1'b0); put(8'h72, 1'b0, 1'b0);
        put(8'h80, 1'b1, 1'b0); put(8'h81, 1'b0, 1'b0); put(8'h82, 1'b0, 1'b1); settle();
        chk(cap_n == 6, "R11", "restart write count", cap_n, 6);
        chk(cap_e[2] == 1'b0, "R11", "cut frame eof", cap_e[2], 0);
        chk(cap_s[3] == 1'b1 && cap_d[3] == 8'h80, "R11", "restart first byte", cap_d[3], 8'h80);
        chk(cap_e[5] == 1'b1 && cap_d[5] == 8'h82, "R11", "restart last byte", cap_d[5], 8'h82);
        cap_n = 0;

        // R11: restart out of a rejected frame, and stray bytes in idle
        addr1_en = 1'b1; addr1_pat = 8'hF0;
        put(8'h00, 1'b1, 1'b0); put(8'h01, 1'b0, 1'b0);
        addr1_pat = 8'h00;
        put(8'h03, 1'b1, 1'b0); put(8'h04, 1'b0, 1'b1);
        put(8'h05, 1'b0, 1'b0); put(8'h06, 1'b0, 1'b1); settle();
        exp_d[0] = 8'h03; exp_d[1] = 8'h04;
        check_writes("R11 restart from drop", 2, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule